// File: doc/BRIEF.md
# Two-Level Masked Interrupt Controller

This block collects interrupt events from eight sources, split into a high-priority group (status bits 3:0) and a low-priority group (status bits 7:4). Each event is latched into an interrupt status word (ISW). A host-loadable mask enables individual sources. A single request line, `irq_o`, goes to the host processor. A level counts as active when at least one of its ISW bits is set and the mask bit for that bit is also set.

When the host acknowledges the request, the block returns a 16-bit tag naming the level being serviced. It then blocks all further requests until the host reports an unconditional branch-out on a strobe input. Every mask write also opens a hold-off window of `HOLD_CYC` clock cycles (default 50) in which no request is raised. A branch-out strobe closes that window at once. Events are still latched into the ISW while requests are blocked, so none is lost.

The host reads the mask or the ISW through a selected read port. It writes either the mask, or a write-one-to-clear pattern to the ISW.

Top module: `two_level_irq_ctrl`

## Requirements
- R1: After reset the ISW and the mask read 0, `irq_o` is 0, `tag_o` is 0x0000, requests are not inhibited and no hold-off is running.
- R2: A 1 on `src_i[k]` at a clock edge sets ISW bit k at that edge. This happens whatever the mask, inhibit or hold-off state is.
- R3: A write with `wr_sel_i`=1 clears every ISW bit whose `wr_data_i` bit is 1. If a source sets the same bit in the same cycle, the set wins.
- R4: A write with `wr_sel_i`=0 loads the mask, which reads back with `rd_sel_i`=0. `rd_sel_i`=1 reads the ISW. A source whose mask bit is 0 never causes a request. With the gate open, `irq_o` rises one edge after an enabled ISW bit becomes visible.
- R5: If both levels are active at the edge where a request is raised, the high level (ISW bits 3:0) is chosen. A low-level request that is already raised is not replaced by a high-level event that arrives later.
- R6: `ack_i` while `irq_o` is 1 drops `irq_o` at that edge and loads `tag_o` with 0x0021 for the high level or 0x0212 for the low level. `ack_i` while `irq_o` is 0 changes nothing.
- R7: After an accepted acknowledge, no request is raised until `branch_out_i` is strobed. The next request can rise one edge after the strobe edge.
- R8: A mask write drops any raised request and starts a hold-off of `HOLD_CYC` cycles. A pending request rises `HOLD_CYC`+1 edges after the write edge, and not before.
- R9: A `branch_out_i` strobe during a hold-off ends the window at once. It also ends the post-acknowledge inhibit.
- R10: A raised request that has not been acknowledged is withdrawn one edge after its level stops being active, for example when its ISW bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 2*SRC_PER_LVL (8) | Interrupt events; bits 3:0 high level, 7:4 low level |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 mask load, 1 ISW write-one-to-clear |
| wr_data_i | input | 2*SRC_PER_LVL (8) | Write data |
| rd_sel_i | input | 1 | Read select: 0 mask, 1 ISW |
| rd_data_o | output | 2*SRC_PER_LVL (8) | Selected register value |
| ack_i | input | 1 | Host acknowledge |
| branch_out_i | input | 1 | Host unconditional branch-out strobe |
| irq_o | output | 1 | Interrupt request to the host |
| tag_o | output | 16 | Tag of the last acknowledged level |

## Verification
The bench counts the edges of the hold-off window exactly. A timer that is off by one would raise `irq_o` one cycle early or late. It checks that two levels becoming enabled together resolve to the high level, and that a low-level request already raised is not preempted: a wrong arbiter would return 0x0021 where 0x0212 is due. A clear and a set on the same ISW bit in the same cycle must leave the bit set, or an event would be lost. Withdrawal after clearing, stray acknowledges, and strobes that end both the inhibit and the hold-off are covered by directed cases and by a long random run checked against a cycle model.

// File: rtl/irq2_pkg.sv
package irq2_pkg;
  typedef enum logic {LVL_HI = 1'b0, LVL_LO = 1'b1} lvl_e;
  typedef enum logic {SEL_MASK = 1'b0, SEL_STAT = 1'b1} reg_sel_e;
  localparam logic [15:0] TAG_HI = 16'h0021;
  localparam logic [15:0] TAG_LO = 16'h0212;
endpackage

// File: rtl/irq2_status.sv
module irq2_status #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_d_i,
  output logic [W-1:0] isw_o,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] isw_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isw_q  <= '0;
      mask_q <= '0;
    end else begin
      isw_q <= (isw_q & ~clr_i) | set_i;  // set wins over clear
      if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  assign isw_o  = isw_q;
  assign mask_o = mask_q;

  // R2
  set_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((isw_q & $past(set_i)) == $past(set_i)));
  // R3
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((isw_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq2_holdoff.sv
module irq2_holdoff #(
  parameter int unsigned HOLD_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic cut_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= CNT_W'(HOLD_CYC);
    else if (cut_i)           cnt_q <= '0;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R8
  hold_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !load_i && !cut_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R9
  hold_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cut_i && !load_i) |=> !busy_o);
endmodule

// File: rtl/irq2_arbiter.sv
module irq2_arbiter
  import irq2_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hi_act_i,
  input  logic        lo_act_i,
  input  logic        hold_i,
  input  logic        flush_i,
  input  logic        ack_i,
  input  logic        bo_i,
  output logic        irq_o,
  output logic [15:0] tag_o
);
  logic req_q, inh_q, open_w, lvl_live;
  lvl_e lvl_q;
  logic [15:0] tag_q;

  assign open_w   = !inh_q && !hold_i;
  assign lvl_live = (lvl_q == LVL_HI) ? hi_act_i : lo_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      inh_q <= 1'b0;
      lvl_q <= LVL_HI;
      tag_q <= '0;
    end else begin
      if (flush_i) begin
        req_q <= 1'b0;
      end else if (req_q && ack_i) begin
        req_q <= 1'b0;
        tag_q <= (lvl_q == LVL_HI) ? TAG_HI : TAG_LO;
      end else if (req_q && !lvl_live) begin
        req_q <= 1'b0;
      end else if (!req_q && open_w && (hi_act_i || lo_act_i)) begin
        req_q <= 1'b1;
        lvl_q <= hi_act_i ? LVL_HI : LVL_LO;
      end
      if (req_q && ack_i && !flush_i) inh_q <= 1'b1;
      else if (bo_i)                  inh_q <= 1'b0;
    end
  end

  assign irq_o = req_q;
  assign tag_o = tag_q;

  // R5
  pri_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_q && open_w && hi_act_i && !flush_i) |=> (req_q && lvl_q == LVL_HI));
  // R6
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && ack_i && !flush_i) |=> (!req_q && inh_q));
  // R7
  inh_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_q && !bo_i) |=> (inh_q && !req_q));
endmodule

// File: rtl/two_level_irq_ctrl.sv
module two_level_irq_ctrl
  import irq2_pkg::*;
#(
  parameter int unsigned SRC_PER_LVL = 4,
  parameter int unsigned HOLD_CYC    = 50
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [2*SRC_PER_LVL-1:0]   src_i,
  input  logic                       wr_en_i,
  input  logic                       wr_sel_i,
  input  logic [2*SRC_PER_LVL-1:0]   wr_data_i,
  input  logic                       rd_sel_i,
  output logic [2*SRC_PER_LVL-1:0]   rd_data_o,
  input  logic                       ack_i,
  input  logic                       branch_out_i,
  output logic                       irq_o,
  output logic [15:0]                tag_o
);
  localparam int unsigned ISW_W = 2 * SRC_PER_LVL;

  logic [ISW_W-1:0] isw_w, mask_w, clr_w;
  logic             mask_we_w, hold_w;
  logic [1:0]       lvl_act_w;

  assign mask_we_w = wr_en_i && (wr_sel_i == SEL_MASK);
  assign clr_w     = (wr_en_i && (wr_sel_i == SEL_STAT)) ? wr_data_i : '0;

  irq2_status #(.W(ISW_W)) i_status (
    .clk_i, .rst_ni,
    .set_i(src_i), .clr_i(clr_w),
    .mask_we_i(mask_we_w), .mask_d_i(wr_data_i),
    .isw_o(isw_w), .mask_o(mask_w)
  );

  // level 0 = ISW[SRC_PER_LVL-1:0] (high), level 1 = upper group (low)
  for (genvar g = 0; g < 2; g++) begin : g_lvl
    assign lvl_act_w[g] = |(isw_w[g*SRC_PER_LVL +: SRC_PER_LVL] &
                            mask_w[g*SRC_PER_LVL +: SRC_PER_LVL]);
  end

  irq2_holdoff #(.HOLD_CYC(HOLD_CYC)) i_holdoff (
    .clk_i, .rst_ni,
    .load_i(mask_we_w), .cut_i(branch_out_i), .busy_o(hold_w)
  );

  irq2_arbiter i_arb (
    .clk_i, .rst_ni,
    .hi_act_i(lvl_act_w[0]), .lo_act_i(lvl_act_w[1]),
    .hold_i(hold_w), .flush_i(mask_we_w),
    .ack_i, .bo_i(branch_out_i),
    .irq_o, .tag_o
  );

  assign rd_data_o = (rd_sel_i == SEL_STAT) ? isw_w : mask_w;

  // R10
  withdraw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i && lvl_act_w == 2'b00) |=> !irq_o);
  // R4
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && lvl_act_w == 2'b00) |=> !irq_o);
endmodule

// File: tb/test_two_level_irq_ctrl.sv
`timescale 1ns/1ps
module test_two_level_irq_ctrl;
  localparam int HOLD = 50;

  logic clk = 0, rst_n = 0;
  logic [7:0] src = 0, wdata = 0, rdata;
  logic wr = 0, wsel = 0, rsel = 0, ack = 0, bo = 0, irq;
  logic [15:0] tag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // cycle model state
  logic [7:0] m_isw = 0, m_mask = 0;
  logic m_req = 0, m_hi = 1, m_inh = 0;
  int   m_cnt = 0;
  logic [15:0] m_tag = 0;

  always #2 clk = ~clk;

  two_level_irq_ctrl #(.SRC_PER_LVL(4), .HOLD_CYC(HOLD)) i_two_level_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr), .wr_sel_i(wsel),
    .wr_data_i(wdata), .rd_sel_i(rsel), .rd_data_o(rdata), .ack_i(ack),
    .branch_out_i(bo), .irq_o(irq), .tag_o(tag));

  function automatic logic lvl_act(input logic [7:0] i, input logic [7:0] m, input logic hi);
    return hi ? |(i[3:0] & m[3:0]) : |(i[7:4] & m[7:4]);
  endfunction

  task automatic model_step();
    logic h = lvl_act(m_isw, m_mask, 1);
    logic l = lvl_act(m_isw, m_mask, 0);
    logic open_w = !m_inh && m_cnt == 0;
    logic mwe = wr && !wsel;
    logic acc = m_req && ack && !mwe;
    logic live = m_hi ? h : l;
    if (mwe) m_req = 0;
    else if (acc) begin m_req = 0; m_tag = m_hi ? 16'h0021 : 16'h0212; end
    else if (m_req && !live) m_req = 0;
    else if (!m_req && open_w && (h || l)) begin m_req = 1; m_hi = h; end
    if (acc) m_inh = 1; else if (bo) m_inh = 0;
    if (mwe) m_cnt = HOLD; else if (bo) m_cnt = 0; else if (m_cnt > 0) m_cnt--;
    m_isw = (m_isw & ~((wr && wsel) ? wdata : 8'h0)) | src;
    if (mwe) m_mask = wdata;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] s = 0, input logic w = 0, input logic sel = 0,
                     input logic [7:0] d = 0, input logic a = 0, input logic b = 0);
    src = s; wr = w; wsel = sel; wdata = d; ack = a; bo = b;
    @(posedge clk);
    model_step();
    #1;
    src = 0; wr = 0; wsel = 0; wdata = 0; ack = 0; bo = 0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    rsel = sel; #0.5; v = rdata;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 tag", tag, 16'h0);
    rd(0, v); chk("R1 mask", v, 0);
    rd(1, v); chk("R1 isw", v, 0);

    // R8 hold-off length, R2 capture during hold-off
    cyc(0, 1, 0, 8'hFF);
    cyc(8'h20);
    rd(1, v); chk("R2 isw during hold-off", v, 8'h20);
    repeat (HOLD - 1) cyc();
    chk("R8 irq still held", irq, 0);
    cyc();
    chk("R8 irq after hold-off", irq, 1);

    // R6 ack tag low level, R7 inhibit
    cyc(0, 0, 0, 0, 1);
    chk("R6 tag low", tag, 16'h0212);
    chk("R6 irq drop", irq, 0);
    cyc(8'h02);
    repeat (4) cyc();
    chk("R7 inhibited", irq, 0);
    rd(1, v); chk("R2 isw while inhibited", v, 8'h22);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R7 at strobe edge", irq, 0);
    cyc();
    chk("R7 after strobe", irq, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R5 both pending picks high", tag, 16'h0021);

    // R6 stray ack ignored
    cyc(0, 0, 0, 0, 1);
    chk("R6 stray ack", tag, 16'h0021);

    // R3 set wins, then clear
    cyc(8'h02, 1, 1, 8'h22);
    rd(1, v); chk("R3 set wins", v, 8'h02);
    cyc(0, 1, 1, 8'h02);
    rd(1, v); chk("R3 clear", v, 8'h00);

    // R9 strobe cuts hold-off, R4 mask
    cyc(0, 1, 0, 8'h0F);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(8'h40);
    repeat (3) cyc();
    chk("R4 masked source quiet", irq, 0);
    rd(0, v); chk("R4 mask readback", v, 8'h0F);
    cyc(8'h04);
    chk("R4 one edge after capture", irq, 0);
    cyc();
    chk("R9 R4 irq without waiting hold-off", irq, 1);

    // R10 withdrawal
    cyc(0, 1, 1, 8'h04);
    chk("R10 still up at clear edge", irq, 1);
    cyc();
    chk("R10 withdrawn", irq, 0);

    // R5 no preemption of raised low-level request
    cyc(0, 1, 0, 8'hFF);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R9 not yet raised", irq, 0);
    cyc(8'h01);
    chk("R5 low raised", irq, 1);
    cyc();
    cyc(0, 0, 0, 0, 1);
    chk("R5 no preempt", tag, 16'h0212);
    cyc(0, 0, 0, 0, 0, 1);

    // random phase against cycle model
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] s = ($urandom % 6 == 0) ? 8'($urandom) : 8'h0;
      logic w = ($urandom % 48 == 0);
      logic sl = (($urandom % 3) != 0);
      logic [7:0] d = 8'($urandom);
      logic a = irq ? ($urandom % 3 == 0) : ($urandom % 10 == 0);
      logic b = ($urandom % 20 == 0);
      cyc(s, w, sl, d, a, b);
      chk("R4 R6 random irq", irq, m_req);
      chk("R6 random tag", tag, m_tag);
      rd(i[0], v);
      chk("R2 R3 random readback", v, i[0] ? m_isw : m_mask);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule